// File: doc/BRIEF.md
# Link-Down Recovery Reset Watchdog

This block supervises a serial link and recovers it when it stays down. A free-running interval timer counts clock cycles while the link-status input reports down. Each time the count reaches the configured interval, the timer starts again from zero and the block issues a limited logic reset. That reset reinitialises the datapath and leaves configuration registers untouched. The timer is held at zero while the link is up or while any loopback mode is active. A loopback test therefore never sees a recovery reset, and a link that comes back up gets a full interval before the next one.

The block also holds a 16-bit command register. Bit 14 of that register is the limited-reset command. Software writes a 1 there to request a reset. The bit then reads 1 for as long as the reset pulse lasts and clears itself when the pulse ends. The other fifteen bits are ordinary configuration storage. The reset pulse leaves them unchanged. The interval and the pulse length are parameters in clock cycles, so a simulation can use short values and silicon can use the multi-second figure.

Top module: `link_recovery_wdog`

## Requirements
- R1: After reset, `logic_rst_o` is 0 and `cmd_rdata_o` reads 0x0000.
- R2: While `link_up_i` and `loopback_i` are both 0, `logic_rst_o` rises once every `INTERVAL_CYCLES` clock cycles. The first rise comes `INTERVAL_CYCLES` clock edges after the timer leaves zero.
- R3: While `link_up_i` is 1, the timer is held at zero and no recovery reset is issued.
- R4: While `loopback_i` is 1, the timer is held at zero and no recovery reset is issued, even when the link is down.
- R5: Each reset pulse keeps `logic_rst_o` at 1 for exactly `PULSE_CYCLES` consecutive cycles.
- R6: A write with bit 14 of `cmd_wdata_i` set, made while no pulse is active, drives `logic_rst_o` to 1 from the next clock edge.
- R7: Bit 14 of `cmd_rdata_o` reads 1 exactly while a pulse is active and returns to 0 by itself when the pulse ends.
- R8: While a pulse is active, a write of bit 14 or a timer expiry has no effect: the pulse neither restarts nor lengthens.
- R9: Bits other than 14 of `cmd_rdata_o` hold the last value written to them. Reset pulses leave them unchanged. Bit 14 is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Link status, 1 = up |
| loopback_i | input | 1 | 1 = some loopback mode active |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command register write data |
| cmd_rdata_o | output | 16 | Command register read value, bit 14 = reset in progress |
| logic_rst_o | output | 1 | Limited logic reset pulse to the datapath |

## Verification
The bench drives three kinds of stimulus: a link that stays down, a link that is up, and a link that is down with loopback active. It counts the pulse edges in each case. A timer that is not held at zero, or that is off by one, shows up as an extra pulse or a shifted one. The bench also writes the reset bit a second time in the middle of a pulse. A design that retriggered on that write would stretch the pulse past its length. Configuration written before a string of automatic resets is read back afterwards, which catches a design that clears the register on a logic reset or that stores bit 14.

// File: rtl/link_wdog_pkg.sv
package link_wdog_pkg;
    typedef enum logic {
        PG_IDLE   = 1'b0,
        PG_ACTIVE = 1'b1
    } pg_state_e;

    localparam int CMD_W   = 16;
    localparam int RST_BIT = 14;
endpackage

// File: rtl/lw_interval_timer.sv
module lw_interval_timer #(
    parameter int INTERVAL_CYCLES = 625_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic expire_o
);
    localparam int CNT_W = (INTERVAL_CYCLES > 2) ? $clog2(INTERVAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            expire_o = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> st_q.cnt == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/lw_pulse_gen.sv
module lw_pulse_gen
    import link_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic busy_o
);
    localparam int LEFT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [LEFT_W-1:0] FIRST = LEFT_W'(PULSE_CYCLES - 1);

    typedef struct packed {
        pg_state_e         state;
        logic [LEFT_W-1:0] left;
    } pg_s;

    pg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.state == PG_ACTIVE) begin
            if (st_q.left == '0) st_d.state = PG_IDLE;
            else                 st_d.left  = st_q.left - 1'b1;
        end else if (req_i) begin
            st_d.state = PG_ACTIVE;
            st_d.left  = FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: PG_IDLE, left: '0};
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.state == PG_ACTIVE);

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> st_q.left == FIRST);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.left != '0) |=> busy_o && st_q.left == $past(st_q.left) - 1'b1);
endmodule

// File: rtl/lw_cmd_reg.sv
module lw_cmd_reg
    import link_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CMD_W-1:0] wdata_i,
    input  logic             busy_i,
    output logic             sw_req_o,
    output logic [CMD_W-1:0] rdata_o
);
    localparam logic [CMD_W-1:0] RST_MASK = CMD_W'(1) << RST_BIT;

    typedef struct packed {
        logic [CMD_W-1:0] cfg;
    } reg_s;

    reg_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sw_req_o = wr_i && wdata_i[RST_BIT];
        if (wr_i) st_d.cfg = wdata_i & ~RST_MASK;
        rdata_o = st_q.cfg | (busy_i ? RST_MASK : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (rdata_o & ~RST_MASK) == ($past(rdata_o) & ~RST_MASK));
endmodule

// File: rtl/link_recovery_wdog.sv
module link_recovery_wdog
    import link_wdog_pkg::*;
#(
    parameter int INTERVAL_CYCLES = 625_000_000,
    parameter int PULSE_CYCLES    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up_i,
    input  logic        loopback_i,
    input  logic        cmd_wr_i,
    input  logic [15:0] cmd_wdata_i,
    output logic [15:0] cmd_rdata_o,
    output logic        logic_rst_o
);
    logic hold, expire, sw_req, busy;

    assign hold = link_up_i || loopback_i;

    lw_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hold),
        .expire_o (expire)
    );

    lw_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (expire || sw_req),
        .busy_o (busy)
    );

    lw_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cmd_wr_i),
        .wdata_i  (cmd_wdata_i),
        .busy_i   (busy),
        .sw_req_o (sw_req),
        .rdata_o  (cmd_rdata_o)
    );

    assign logic_rst_o = busy;

    // R6
    sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_wdata_i[RST_BIT] && !logic_rst_o) |=> logic_rst_o);

    // R4
    lb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback_i && !logic_rst_o) |=> !logic_rst_o || $past(cmd_wr_i && cmd_wdata_i[RST_BIT]));
endmodule

// File: tb/link_recovery_wdog_tb.sv
module link_recovery_wdog_tb;
    localparam int INTV  = 40;
    localparam int PULSE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        lb = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        lrst;

    int checks = 0;
    int fails = 0;
    string phase = "R1";

    // behavioural reference model
    int m_cnt = 0;
    int m_busy = 0;
    logic [15:0] m_cfg = '0;
    int rises = 0;
    logic prev_rst = 1'b0;

    always #4 clk = ~clk;

    link_recovery_wdog #(.INTERVAL_CYCLES(INTV), .PULSE_CYCLES(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .loopback_i(lb),
        .cmd_wr_i(wr), .cmd_wdata_i(wdata), .cmd_rdata_o(rdata), .logic_rst_o(lrst)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_busy = 0; m_cfg = '0;
        end else begin
            bit expd;
            expd = 1'b0;
            if (link_up || lb) m_cnt = 0;
            else if (m_cnt == INTV - 1) begin m_cnt = 0; expd = 1'b1; end
            else m_cnt = m_cnt + 1;
            if (m_busy > 0) m_busy = m_busy - 1;
            else if (expd || (wr && wdata[14])) m_busy = PULSE;
            if (wr) m_cfg = wdata & 16'hBFFF;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " model rst"}, 32'(lrst), 32'(m_busy > 0));
            check({phase, " model rdata"}, 32'(rdata), 32'(m_cfg | ((m_busy > 0) ? 16'h4000 : 16'h0)));
            if (lrst && !prev_rst) rises++;
            prev_rst = lrst;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [15:0] d);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic width(input string req, input int exp);
        int w = 0;
        while (lrst && w < 100) begin w++; @(negedge clk); end
        check(req, 32'(w), 32'(exp));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 rst", 32'(lrst), 0);
        check("R1 rdata", 32'(rdata), 0);
        rst_n = 1'b1;
        cyc(2);

        phase = "R3"; rises = 0;
        cyc(100);
        check("R3 no pulses with link up", 32'(rises), 0);

        phase = "R4"; link_up = 1'b0; lb = 1'b1; rises = 0;
        cyc(100);
        check("R4 no pulses in loopback", 32'(rises), 0);

        phase = "R2"; lb = 1'b0; rises = 0;
        cyc(39);
        check("R2 no pulse before interval", 32'(lrst), 0);
        cyc(1);
        check("R2 first pulse at interval", 32'(lrst), 1);
        phase = "R5";
        width("R5 auto pulse width", PULSE);
        phase = "R2";
        cyc(130 - 40 - PULSE);
        check("R2 three pulses in 130 cycles", 32'(rises), 3);

        phase = "R6"; link_up = 1'b1;
        cyc(10);
        write(16'h4123);
        check("R6 pulse after write", 32'(lrst), 1);
        check("R7 bit14 during pulse", 32'(rdata[14]), 1);
        width("R5 sw pulse width", PULSE);
        check("R7 bit14 self-clears", 32'(rdata[14]), 0);
        check("R9 cfg kept", 32'(rdata), 32'h0123);

        phase = "R8";
        cyc(3);
        write(16'h4123);
        cyc(1);
        write(16'h4123);
        width("R8 pulse not extended", PULSE - 2);
        check("R8 idle after pulse", 32'(lrst), 0);

        phase = "R9";
        write(16'h8ABC);
        link_up = 1'b0; rises = 0;
        cyc(125);
        check("R9 auto pulses occurred", 32'(rises), 3);
        link_up = 1'b1;
        cyc(10);
        check("R9 cfg survives resets", 32'(rdata), 32'h8ABC);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule